// File: doc/BRIEF.md
# Configuration Request Bus-Number Router

This block sits on the upstream side of a bus-to-bus bridge and decides what happens to each configuration request the bridge sees. A request arrives as a 32-bit address word whose two low bits give its format. Format `01` is a request aimed at some bus further down the tree, and it carries a register, function, device and bus field. The block compares the bus field with the secondary and subordinate bus numbers held in its own registers, and then does one of three things:
- drops the request;
- passes it downstream untouched, still aimed at a bus further down;
- rewrites it as a local request for the bus directly behind the bridge, with the device number turned into a one-hot slot select.

Software fills in the three bus-number registers (primary, secondary, subordinate) through a small write/read port. The routing decision is held in a four-state machine. `ST_IDLE` is entered on any cycle with no request. `ST_DROP`, `ST_PASS` and `ST_CONV` are each entered for exactly one cycle after a request that was dropped, passed or converted. The next state depends only on the current request, so every state can move to any other state on the next edge.

Top module: `cfg_route_bridge`

## Requirements
- R1: After reset, all three bus-number registers read zero. The block shows no output valid and no drop indication until a request arrives.
- R2: The write port uses select codes 0 = primary, 1 = secondary, 2 = subordinate. A write with code 3 is discarded. The read port returns the selected register, and returns zero for code 3.
- R3: A request whose address bits 1:0 are not `01` is never sent downstream. It is reported as dropped.
- R4: A request with bits 1:0 = `01` whose bus field (bits 23:16) is greater than the secondary number and no greater than the subordinate number is presented downstream as a forward-type request. Its 32-bit address is unchanged.
- R5: A request with bits 1:0 = `01` whose bus field equals the secondary number is converted. The output has bits 1:0 = `00` and bits 10:2 (function and register) copied. For device number d (bits 15:11), bit 11+d is set, and every other bit in 31:11 is clear.
- R6: A converted request whose device number is above 20 carries no select bit: bits 31:11 are all zero.
- R7: A request with bits 1:0 = `01` whose bus field is below the secondary number or above the subordinate number is dropped. While the secondary number is zero, every request is dropped.
- R8: With the subordinate number at 0xFF, every bus number above the secondary number is forwarded.
- R9: When a register write and a request fall on the same clock edge, the request is routed with the register values held before that write.
- R10: Each request produces exactly one result one cycle after it is taken: either output valid or drop, never both. A cycle without a request produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Bus-number register write strobe |
| reg_wr_sel | input | 2 | Register select for writes (0 primary, 1 secondary, 2 subordinate) |
| reg_wr_data | input | 8 | Write data |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | 8 | Selected register value |
| req_valid | input | 1 | Configuration request present this cycle |
| req_addr | input | 32 | Request address word |
| out_valid | output | 1 | Request presented on the secondary side |
| out_fwd | output | 1 | 1: forwarded unchanged, 0: converted to local form |
| out_addr | output | 32 | Secondary-side address word |
| req_dropped | output | 1 | Request was not claimed |

## Verification
A write to the secondary or subordinate register can land on the same edge as a request whose bus number sits exactly on the edge of the old or new range. The routing must then follow the old values. The bench provokes this by issuing a write and a request together in many random cycles, with bus numbers drawn next to both bounds. Its reference model decides each request before it applies the write. A mismatch in result kind or address is reported against R9.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
    typedef enum logic [1:0] {
        RT_DROP = 2'd0,
        RT_PASS = 2'd1,
        RT_CONV = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DROP = 2'd1,
        ST_PASS = 2'd2,
        ST_CONV = 2'd3
    } rstate_e;

    localparam logic [1:0] SEL_PRI = 2'd0;
    localparam logic [1:0] SEL_SEC = 2'd1;
    localparam logic [1:0] SEL_SUB = 2'd2;
    localparam logic [1:0] FMT_FWD = 2'b01;
    localparam logic [1:0] FMT_LOC = 2'b00;
endpackage

// File: rtl/cfg_busnum_regs.sv
module cfg_busnum_regs
    import cfg_route_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [BUS_W-1:0] rd_data,
    output logic [BUS_W-1:0] sec_num,
    output logic [BUS_W-1:0] sub_num
);
    logic [BUS_W-1:0] pri_q, sec_q, sub_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '0;
            sec_q <= '0;
            sub_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PRI) pri_q <= wr_data;
            if (wr_sel == SEL_SEC) sec_q <= wr_data;
            if (wr_sel == SEL_SUB) sub_q <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_sel)
            SEL_PRI: rd_data = pri_q;
            SEL_SEC: rd_data = sec_q;
            SEL_SUB: rd_data = sub_q;
            default: rd_data = '0;
        endcase
    end

    assign sec_num = sec_q;
    assign sub_num = sub_q;

    // R2: registers change only on a write strobe
    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({pri_q, sec_q, sub_q}));
    // R2: code 3 writes are discarded
    a_r2_sel3_discarded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> $stable({pri_q, sec_q, sub_q}));
endmodule

// File: rtl/cfg_route_decide.sv
module cfg_route_decide
    import cfg_route_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic [1:0]       fmt,
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] sec_num,
    input  logic [BUS_W-1:0] sub_num,
    output route_e           route
);
    always_comb begin
        if (fmt != FMT_FWD || sec_num == '0)
            route = RT_DROP;
        else if (bus == sec_num)
            route = RT_CONV;
        else if (bus > sec_num && bus <= sub_num)
            route = RT_PASS;
        else
            route = RT_DROP;
    end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
    parameter int ADDR_W  = 32,
    parameter int SEL_LSB = 11,
    parameter int DEV_W   = 5
) (
    input  logic [SEL_LSB-1:2] low_fields,
    input  logic [DEV_W-1:0]   dev,
    output logic [ADDR_W-1:0]  loc_addr
);
    localparam int NUM_SEL = ADDR_W - SEL_LSB;

    logic [NUM_SEL-1:0] sel;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel[g] = (32'(dev) == 32'(g));
    end

    assign loc_addr = {sel, low_fields, 2'b00};
endmodule

// File: rtl/cfg_route_bridge.sv
module cfg_route_bridge
    import cfg_route_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int BUS_W   = 8,
    parameter int BUS_LSB = 16,
    parameter int SEL_LSB = 11,
    parameter int DEV_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [BUS_W-1:0]  reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [BUS_W-1:0]  reg_rd_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic              out_fwd,
    output logic [ADDR_W-1:0] out_addr,
    output logic              req_dropped
);
    localparam int NUM_SEL = ADDR_W - SEL_LSB;

    logic [BUS_W-1:0]  sec_num, sub_num;
    route_e            route;
    logic [ADDR_W-1:0] loc_addr;
    rstate_e           state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    cfg_busnum_regs #(.BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
        .rd_sel(reg_rd_sel), .rd_data(reg_rd_data),
        .sec_num(sec_num), .sub_num(sub_num)
    );

    cfg_route_decide #(.BUS_W(BUS_W)) u_decide (
        .fmt(req_addr[1:0]), .bus(req_addr[BUS_LSB +: BUS_W]),
        .sec_num(sec_num), .sub_num(sub_num), .route(route)
    );

    cfg_addr_xlate #(.ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .DEV_W(DEV_W)) u_xlate (
        .low_fields(req_addr[SEL_LSB-1:2]),
        .dev(req_addr[SEL_LSB +: DEV_W]),
        .loc_addr(loc_addr)
    );

    always_comb begin
        if (!req_valid) state_d = ST_IDLE;
        else begin
            unique case (route)
                RT_PASS: state_d = ST_PASS;
                RT_CONV: state_d = ST_CONV;
                default: state_d = ST_DROP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid)
                addr_q <= (route == RT_CONV) ? loc_addr : req_addr;
        end
    end

    always_comb begin
        out_valid   = 1'b0;
        out_fwd     = 1'b0;
        req_dropped = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DROP: req_dropped = 1'b1;
            ST_PASS: begin out_valid = 1'b1; out_fwd = 1'b1; end
            ST_CONV: out_valid = 1'b1;
        endcase
    end
    assign out_addr = addr_q;

    // R3: non-forward formats are always dropped
    a_r3_local_never_sent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != FMT_FWD) |=> (req_dropped && !out_valid));
    // R4: forwarded address equals the request
    a_r4_pass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fwd) |-> (out_addr == $past(req_addr)));
    // R5 R6: converted output carries at most one select and local format
    a_r5_conv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fwd) |-> ($countones(out_addr[ADDR_W-1:SEL_LSB]) <= 1
                                     && out_addr[1:0] == FMT_LOC));
    // R7: nothing claimed while secondary number is zero
    a_r7_unprogrammed_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sec_num == '0) |=> req_dropped);
    // R10: one result per request, none without
    a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_valid ^ req_dropped));
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && !req_dropped));

    initial begin
        a_r6_sel_width: assert (NUM_SEL >= 1);
    end
endmodule

// File: tb/cfg_route_bridge_bench.sv
module cfg_route_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [7:0]  reg_rd_data;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid, out_fwd, req_dropped;
    logic [31:0] out_addr;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [7:0] m_pri = 0, m_sec = 0, m_sub = 0;

    always #4 clk = ~clk;

    cfg_route_bridge u_cfg_route_bridge (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_fwd(out_fwd), .out_addr(out_addr),
        .req_dropped(req_dropped)
    );

    // 0 none, 1 drop, 2 pass, 3 convert
    function automatic int exp_kind(logic v, logic [31:0] a, logic [7:0] s, logic [7:0] u);
        if (!v) return 0;
        if (a[1:0] != 2'b01 || s == 0) return 1;
        if (a[23:16] == s) return 3;
        if (a[23:16] > s && a[23:16] <= u) return 2;
        return 1;
    endfunction

    function automatic logic [31:0] exp_conv(logic [31:0] a);
        logic [31:0] r;
        r = {21'b0, a[10:2], 2'b00};
        if (a[15:11] <= 5'd20) r[11 + a[15:11]] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] model_rd(logic [1:0] s);
        case (s)
            2'd0: return m_pri;
            2'd1: return m_sec;
            2'd2: return m_sub;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; applies inputs, one posedge, checks at next negedge
    task automatic step(logic we, logic [1:0] ws, logic [7:0] wd,
                        logic rv, logic [31:0] ra, logic [1:0] rs, string tag);
        int k;
        logic [31:0] ea;
        reg_wr_en = we; reg_wr_sel = ws; reg_wr_data = wd;
        req_valid = rv; req_addr = ra; reg_rd_sel = rs;
        k = exp_kind(rv, ra, m_sec, m_sub);   // R9: decided before the write
        ea = (k == 3) ? exp_conv(ra) : ra;
        if (we) begin
            if (ws == 2'd0) m_pri = wd;
            if (ws == 2'd1) m_sec = wd;
            if (ws == 2'd2) m_sub = wd;
        end
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0; req_valid = 1'b0;
        check({tag, " R10 valid"}, {31'b0, out_valid}, {31'b0, k >= 2});
        check({tag, " R10 drop"}, {31'b0, req_dropped}, {31'b0, k == 1});
        if (k >= 2) begin
            check({tag, " R4/R5 kind"}, {31'b0, out_fwd}, {31'b0, k == 2});
            check({tag, " R4/R5/R6 addr"}, out_addr, ea);
        end
        check({tag, " R2 read"}, {24'b0, reg_rd_data}, {24'b0, model_rd(rs)});
    endtask

    function automatic logic [31:0] mk1(logic [7:0] bus, logic [4:0] dev,
                                        logic [2:0] fn, logic [5:0] rg);
        return {8'h00, bus, dev, fn, rg, 2'b01};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 out_valid", {31'b0, out_valid}, 0);
        check("R1 drop", {31'b0, req_dropped}, 0);
        for (int s = 0; s < 3; s++) begin
            reg_rd_sel = 2'(s); #1;
            check("R1 regs zero", {24'b0, reg_rd_data}, 0);
        end
        @(negedge clk);
        // R7: unprogrammed bridge claims nothing, bus 0 included
        step(0, 0, 0, 1, mk1(8'h00, 5'd0, 3'd0, 6'd0), 2'd1, "R7 unprog bus0");
        step(0, 0, 0, 1, mk1(8'h05, 5'd1, 3'd0, 6'd0), 2'd1, "R7 unprog bus5");
        // R2 programming and code 3 discard
        step(1, 2'd0, 8'h01, 0, 0, 2'd0, "R2 pri");
        step(1, 2'd1, 8'h03, 0, 0, 2'd1, "R2 sec");
        step(1, 2'd2, 8'h06, 0, 0, 2'd2, "R2 sub");
        step(1, 2'd3, 8'hAA, 0, 0, 2'd3, "R2 sel3");
        step(0, 0, 0, 0, 0, 2'd1, "R2 sec kept");
        // R5 conversion, slot 0 and slot 1
        step(0, 0, 0, 1, mk1(8'h03, 5'd0, 3'd5, 6'h2A), 2'd0, "R5 slot0");
        step(0, 0, 0, 1, mk1(8'h03, 5'd1, 3'd2, 6'h11), 2'd0, "R5 slot1");
        step(0, 0, 0, 1, mk1(8'h03, 5'd20, 3'd7, 6'h3F), 2'd0, "R5 slot20");
        // R6 too-large device numbers
        step(0, 0, 0, 1, mk1(8'h03, 5'd21, 3'd1, 6'h01), 2'd0, "R6 dev21");
        step(0, 0, 0, 1, mk1(8'h03, 5'd31, 3'd1, 6'h01), 2'd0, "R6 dev31");
        // R4 forward at range edges, R7 outside
        step(0, 0, 0, 1, mk1(8'h04, 5'd3, 3'd0, 6'd4) | 32'hAB00_0000, 2'd0, "R4 sec+1");
        step(0, 0, 0, 1, mk1(8'h06, 5'd3, 3'd0, 6'd4), 2'd0, "R4 sub");
        step(0, 0, 0, 1, mk1(8'h07, 5'd3, 3'd0, 6'd4), 2'd0, "R7 above");
        step(0, 0, 0, 1, mk1(8'h02, 5'd3, 3'd0, 6'd4), 2'd0, "R7 below");
        // R3 local and reserved formats
        step(0, 0, 0, 1, {mk1(8'h03, 5'd1, 3'd0, 6'd0)} & ~32'h3, 2'd0, "R3 fmt00");
        step(0, 0, 0, 1, mk1(8'h04, 5'd1, 3'd0, 6'd0) | 32'h3, 2'd0, "R3 fmt11");
        // R8 temporary 0xFF subordinate
        step(1, 2'd2, 8'hFF, 0, 0, 2'd2, "R8 set");
        step(0, 0, 0, 1, mk1(8'hFF, 5'd2, 3'd0, 6'd0), 2'd0, "R8 bus255");
        step(0, 0, 0, 1, mk1(8'h80, 5'd2, 3'd0, 6'd0), 2'd0, "R8 bus128");
        // R9 write and request together
        step(1, 2'd1, 8'h05, 1, mk1(8'h03, 5'd4, 3'd0, 6'd0), 2'd1, "R9 old sec conv");
        step(1, 2'd2, 8'h05, 1, mk1(8'h09, 5'd4, 3'd0, 6'd0), 2'd2, "R9 old sub pass");
        step(0, 0, 0, 1, mk1(8'h09, 5'd4, 3'd0, 6'd0), 2'd2, "R9 new sub drop");
        // random mix (R4 R5 R7 R9)
        void'($urandom(32'd1234));
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] bus;
            logic [31:0] a;
            int pick;
            pick = $urandom_range(0, 6);
            case (pick)
                0: bus = m_sec;
                1: bus = m_sec + 8'd1;
                2: bus = m_sub;
                3: bus = m_sub + 8'd1;
                4: bus = m_sec - 8'd1;
                default: bus = 8'($urandom);
            endcase
            a = $urandom;
            a[23:16] = bus;
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b01;
            step(($urandom_range(0, 3) == 0), 2'($urandom), 8'($urandom_range(0, 12)),
                 ($urandom_range(0, 4) != 0), a, 2'($urandom), "R9 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule